// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block turns a page number and a start strobe into the ordered list of flash operations that brings one NAND page into a controller's internal page buffer. It issues command writes, address-byte writes and data-output requests on a small operation interface. After each operation it waits for a ready flag from the flash side and clears that flag before it moves on. Only one operation is ever in flight.

The page geometry is fixed by parameters: page size, chunk size and the device's total page count. A page larger than one chunk is a large-page device. Such a device gets an extra column byte, a confirm command after the address, and one data-output request per chunk. The number of row-address bytes is derived when the block is built. It is the number of bytes needed to hold the largest page index, and it is never less than one. The NAND timing, the buffer RAM and error correction sit outside the block and are seen only through the ready/clear handshake.

Top module: `nand_page_rd_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `op_clr` are 0, `op_type` is 0 and `op_buf_idx` is 0.
- R2: The first operation after an accepted start is a command (`op_type` = 3'b001) with data 0x00, and `op_buf_idx` is 0 for every operation before the first data-output request.
- R3: After the first command comes an address write (`op_type` = 3'b010) of 0x00. When the page size exceeds the chunk size, a second 0x00 address write follows.
- R4: The row address is sent as address writes, least significant byte first. There are as many writes as bytes needed to hold (total pages − 1), with a minimum of one. Write k carries bits [8k+7:8k] of the page number.
- R5: When the page number is greater than the total page count, no row bytes are sent. A page number equal to the count still sends them.
- R6: After the row bytes, or where they would stand, one address write of 0x00 is always sent.
- R7: When the page size exceeds the chunk size, a command of 0x30 follows the trailing address byte.
- R8: Data-output requests (`op_type` = 3'b100, data 0x00) follow. There is one per chunk, with `op_buf_idx` equal to 0, 1, … up to chunks − 1 in that order.
- R9: Each operation is a one-cycle pulse with `op_type` one-hot. The next operation is not issued until `op_ready` has been seen high and `op_clr` has pulsed for one cycle. `op_clr` rises the cycle after `op_ready` is first sampled high, and the next operation appears the cycle after `op_clr`.
- R10: `done` pulses for one cycle, together with the `op_clr` of the last data-output request, and `busy` is low in the following cycle.
- R11: A start while `busy` is high is ignored: the running sequence is not changed and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin reading the page on `page_num` (taken only when idle) |
| page_num | input | PAGE_W | Page index to read |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the page read is complete |
| op_type | output | 3 | One-hot operation strobe: bit0 command, bit1 address, bit2 data output |
| op_data | output | 8 | Command or address byte for the strobed operation |
| op_buf_idx | output | IDX_W | Internal buffer index (chunk) for data-output requests |
| op_ready | input | 1 | Ready/interrupt flag from the flash side |
| op_clr | output | 1 | One-cycle pulse clearing the ready flag |

## Verification
The first operation strobe is due in the cycle after the clock edge that samples `start`. Each `op_clr` is due in the cycle after the edge that samples `op_ready` high, and the next strobe in the cycle after that. `done` is due in the same cycle as the final `op_clr`. The bench changes its inputs and samples the outputs on the falling edge. A responder raises `op_ready` after a varying delay of zero to three cycles. A scoreboard checks each strobe against the expected type, byte and buffer index at the moment it appears, so a shifted, missing or extra operation is reported where it happens.

// File: rtl/nprs_pkg.sv
package nprs_pkg;

    typedef enum logic [2:0] {
        ST_CMD_READ,
        ST_COL_LO,
        ST_COL_HI,
        ST_ROW,
        ST_TAIL,
        ST_CMD_CONF,
        ST_XFER
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_WAIT,
        PH_CLEAR
    } phase_e;

    localparam logic [2:0] OPK_NONE = 3'b000;
    localparam logic [2:0] OPK_CMD  = 3'b001;
    localparam logic [2:0] OPK_ADDR = 3'b010;
    localparam logic [2:0] OPK_XFER = 3'b100;

    localparam logic [7:0] CMD_READ_SETUP   = 8'h00;
    localparam logic [7:0] CMD_READ_CONFIRM = 8'h30;
    localparam logic [7:0] ADDR_ZERO        = 8'h00;

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] data;
    } flash_op_t;

    // Bytes needed to hold (total_pages - 1), never fewer than one.
    function automatic int unsigned row_byte_count(input longint unsigned total_pages);
        longint unsigned v;
        int unsigned     n;
        n = 1;
        v = (total_pages - 1) >> 8;
        for (int i = 0; i < 8; i++) begin
            if (v != 0) begin
                n = n + 1;
                v = v >> 8;
            end
        end
        return n;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nprs_step_plan.sv
module nprs_step_plan
    import nprs_pkg::*;
#(
    parameter int unsigned PAGE_BYTES  = 2048,
    parameter int unsigned CHUNK_BYTES = 512,
    parameter int unsigned TOTAL_PAGES = 65536,
    parameter int unsigned PAGE_W      = 32,
    parameter int unsigned IDX_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [PAGE_W-1:0] page_num,
    output flash_op_t         op,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              last
);
    localparam int unsigned NCHUNK = PAGE_BYTES / CHUNK_BYTES;
    localparam int unsigned ROW_N  = row_byte_count(longint'(TOTAL_PAGES));
    localparam int unsigned SUB_W  = width_of(max_of(ROW_N, NCHUNK)) + 1;
    localparam bit          LARGE  = (PAGE_BYTES > CHUNK_BYTES);
    localparam logic [PAGE_W-1:0] TOTAL_P  = PAGE_W'(TOTAL_PAGES);
    localparam logic [SUB_W-1:0]  ROW_LAST = SUB_W'(ROW_N - 1);
    localparam logic [SUB_W-1:0]  XFR_LAST = SUB_W'(NCHUNK - 1);

    step_e             step, step_nxt;
    logic [SUB_W-1:0]  sub, sub_nxt;
    logic [PAGE_W-1:0] row_sh;
    logic              row_ok;
    step_e             after_col;
    step_e             after_tail;

    // Geometry picks the successors of the column and trailing steps.
    generate
        if (LARGE) begin : g_large
            assign after_tail = ST_CMD_CONF;
        end else begin : g_small
            assign after_tail = ST_XFER;
        end
    endgenerate

    assign after_col = row_ok ? ST_ROW : ST_TAIL;

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= ST_CMD_READ;
            sub    <= '0;
            row_sh <= '0;
            row_ok <= 1'b0;
        end else if (load) begin
            step   <= ST_CMD_READ;
            sub    <= '0;
            row_sh <= page_num;
            row_ok <= (page_num <= TOTAL_P);
        end else if (advance) begin
            step <= step_nxt;
            sub  <= sub_nxt;
            if (step == ST_ROW) row_sh <= row_sh >> 8;
        end
    end

    always_comb begin
        step_nxt = step;
        sub_nxt  = '0;
        unique case (step)
            ST_CMD_READ: step_nxt = ST_COL_LO;
            ST_COL_LO:   step_nxt = LARGE ? ST_COL_HI : after_col;
            ST_COL_HI:   step_nxt = after_col;
            ST_ROW: begin
                if (sub == ROW_LAST) begin
                    step_nxt = ST_TAIL;
                end else begin
                    step_nxt = ST_ROW;
                    sub_nxt  = sub + 1'b1;
                end
            end
            ST_TAIL:     step_nxt = after_tail;
            ST_CMD_CONF: step_nxt = ST_XFER;
            ST_XFER: begin
                step_nxt = ST_XFER;
                sub_nxt  = sub + 1'b1;
            end
            default:     step_nxt = ST_CMD_READ;
        endcase
    end

    always_comb begin
        op = '{kind: OPK_NONE, data: 8'h00};
        unique case (step)
            ST_CMD_READ: op = '{kind: OPK_CMD,  data: CMD_READ_SETUP};
            ST_COL_LO:   op = '{kind: OPK_ADDR, data: ADDR_ZERO};
            ST_COL_HI:   op = '{kind: OPK_ADDR, data: ADDR_ZERO};
            ST_ROW:      op = '{kind: OPK_ADDR, data: row_sh[7:0]};
            ST_TAIL:     op = '{kind: OPK_ADDR, data: ADDR_ZERO};
            ST_CMD_CONF: op = '{kind: OPK_CMD,  data: CMD_READ_CONFIRM};
            ST_XFER:     op = '{kind: OPK_XFER, data: 8'h00};
            default:     op = '{kind: OPK_NONE, data: 8'h00};
        endcase
    end

    assign buf_idx = (step == ST_XFER) ? sub[IDX_W-1:0] : '0;
    assign last    = (step == ST_XFER) && (sub == XFR_LAST);

    // R5: row bytes are only ever visited for an in-range page
    p_row_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ROW) |-> row_ok);
    // R4: row byte index stays inside the derived count
    p_row_count_r4: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ROW) |-> (sub <= ROW_LAST));
    // R8: chunk index stays inside the page
    p_xfer_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (step == ST_XFER) |-> (sub <= XFR_LAST));

endmodule

// File: rtl/nprs_phase_ctrl.sv
module nprs_phase_ctrl
    import nprs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_ready,
    input  logic last,
    output logic load,
    output logic issue,
    output logic advance,
    output logic clr,
    output logic done,
    output logic busy
);
    phase_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE;
        end else begin
            unique case (ph)
                PH_IDLE:  if (start) ph <= PH_ISSUE;
                PH_ISSUE: ph <= PH_WAIT;
                PH_WAIT:  if (op_ready) ph <= PH_CLEAR;
                PH_CLEAR: ph <= last ? PH_IDLE : PH_ISSUE;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    assign load    = (ph == PH_IDLE) && start;
    assign issue   = (ph == PH_ISSUE);
    assign clr     = (ph == PH_CLEAR);
    assign advance = clr && !last;
    assign done    = clr && last;
    assign busy    = (ph != PH_IDLE);

    // R9: the flag is cleared only after it was seen set
    p_clr_after_ready_r9: assert property (@(posedge clk) disable iff (rst)
        clr |-> $past(op_ready));
    // R10: completion is a single-cycle pulse followed by idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R11: a running sequence is never restarted
    p_no_reload_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/nand_page_rd_seq.sv
module nand_page_rd_seq
    import nprs_pkg::*;
#(
    parameter int unsigned PAGE_BYTES  = 2048,
    parameter int unsigned CHUNK_BYTES = 512,
    parameter int unsigned TOTAL_PAGES = 65536,
    parameter int unsigned PAGE_W      = 32,
    localparam int unsigned NCHUNK     = PAGE_BYTES / CHUNK_BYTES,
    localparam int unsigned IDX_W      = width_of(NCHUNK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_num,
    output logic              busy,
    output logic              done,
    output logic [2:0]        op_type,
    output logic [7:0]        op_data,
    output logic [IDX_W-1:0]  op_buf_idx,
    input  logic              op_ready,
    output logic              op_clr
);
    flash_op_t cur_op;
    logic      load, issue, advance, last;

    nprs_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_ready (op_ready),
        .last     (last),
        .load     (load),
        .issue    (issue),
        .advance  (advance),
        .clr      (op_clr),
        .done     (done),
        .busy     (busy)
    );

    nprs_step_plan #(
        .PAGE_BYTES  (PAGE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES),
        .TOTAL_PAGES (TOTAL_PAGES),
        .PAGE_W      (PAGE_W),
        .IDX_W       (IDX_W)
    ) u_plan (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .page_num (page_num),
        .op       (cur_op),
        .buf_idx  (op_buf_idx),
        .last     (last)
    );

    assign op_type = issue ? cur_op.kind : OPK_NONE;
    assign op_data = issue ? cur_op.data : 8'h00;

    // R9: at most one operation kind strobed at a time
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_type));
    // R9: a strobe lasts one cycle, then the block waits for the flag
    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (rst)
        (op_type != OPK_NONE) |=> (op_type == OPK_NONE));
    // R10: completion coincides with a flag clear
    p_done_with_clr_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> op_clr);

endmodule

// File: tb/nand_page_rd_seq_tb.sv
module nand_page_rd_seq_tb;
    localparam int unsigned PAGE_BYTES  = 2048;
    localparam int unsigned CHUNK_BYTES = 512;
    localparam int unsigned TOTAL_PAGES = 65536;
    localparam int unsigned PAGE_W      = 32;
    localparam int unsigned NCHUNK      = PAGE_BYTES / CHUNK_BYTES;
    localparam int unsigned IDX_W       = 2;
    localparam int unsigned ROW_N       = 2;   // bytes to hold 65535

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [PAGE_W-1:0] page_num = '0;
    logic              busy, done, op_clr;
    logic [2:0]        op_type;
    logic [7:0]        op_data;
    logic [IDX_W-1:0]  op_buf_idx;
    logic              op_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    // expected item: {type, data, idx}
    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    nand_page_rd_seq #(
        .PAGE_BYTES  (PAGE_BYTES),
        .CHUNK_BYTES (CHUNK_BYTES),
        .TOTAL_PAGES (TOTAL_PAGES),
        .PAGE_W      (PAGE_W)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .page_num   (page_num),
        .busy       (busy),
        .done       (done),
        .op_type    (op_type),
        .op_data    (op_data),
        .op_buf_idx (op_buf_idx),
        .op_ready   (op_ready),
        .op_clr     (op_clr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] t, input logic [7:0] d, input logic [1:0] i, input string req);
        exp_q.push_back({t, d, i});
        tag_q.push_back(req);
    endtask

    // Driver: expected sequence built from the requirements.
    task automatic push_read(input logic [PAGE_W-1:0] pg);
        push(3'b001, 8'h00, 2'd0, "R2");
        push(3'b010, 8'h00, 2'd0, "R3");
        push(3'b010, 8'h00, 2'd0, "R3");
        if (pg <= PAGE_W'(TOTAL_PAGES)) begin
            for (int k = 0; k < ROW_N; k++)
                push(3'b010, 8'((pg >> (8 * k)) & 32'hFF), 2'd0, "R4");
        end
        push(3'b010, 8'h00, 2'd0, "R6");
        push(3'b001, 8'h30, 2'd0, "R7");
        for (int c = 0; c < NCHUNK; c++)
            push(3'b100, 8'h00, 2'(c), "R8");
    endtask

    // Monitor: compare every strobe against the scoreboard.
    bit outstanding = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && op_type != 3'b000) begin
                check(!outstanding, "R9 strobe while outstanding", 32'(op_type), 32'd0);
                outstanding = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected operation", {19'd0, op_type, op_data, op_buf_idx}, 32'd0);
                end else begin
                    logic [12:0] e;
                    string       r;
                    e = exp_q.pop_front();
                    r = tag_q.pop_front();
                    check({op_type, op_data, op_buf_idx} == e, r, {19'd0, op_type, op_data, op_buf_idx}, {19'd0, e});
                end
            end
            if (!rst && op_clr) begin
                check(op_ready && outstanding, "R9 clear without ready", {30'd0, op_ready, outstanding}, 32'd3);
                outstanding = 1'b0;
            end
        end
    end

    // Responder: raise the flag after 0..3 cycles, drop it after the clear.
    int lat_seed = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && op_type != 3'b000) begin
                repeat (lat_seed % 4) @(negedge clk);
                lat_seed++;
                op_ready = 1'b1;
                do @(negedge clk); while (!op_clr);
                @(posedge clk);
                #1 op_ready = 1'b0;
            end
        end
    end

    task automatic run_read(input logic [PAGE_W-1:0] pg, input bit poke_busy);
        int n;
        push_read(pg);
        @(negedge clk);
        start    = 1'b1;
        page_num = pg;
        @(negedge clk);
        start    = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start    = 1'b1;
            page_num = 32'h0000_0077;
            @(negedge clk);
            start    = 1'b0;
        end
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(done && op_clr, "R10 done with last clear", {30'd0, done, op_clr}, 32'd3);
        check(exp_q.size() == 0, "R8 all operations seen", 32'(exp_q.size()), 32'd0);
        @(negedge clk);
        check(!done && !busy, "R10 idle after done", {30'd0, done, busy}, 32'd0);
        repeat (6) @(negedge clk);
        check(!busy, "R11 no second sequence", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!busy && !done && !op_clr && op_type == 3'b000 && op_buf_idx == '0,
              "R1 reset state", {27'd0, busy, done, op_clr, op_type == 3'b000, op_buf_idx == '0}, 32'd3);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_read(32'h0000_1234, 1'b0);
        run_read(32'h0000_ABCD, 1'b1);   // R11 start while busy
        run_read(32'h0000_FFFF, 1'b0);
        run_read(32'h0001_0000, 1'b0);   // R5 equal to count: rows sent
        run_read(32'h0001_0001, 1'b0);   // R5 above count: rows skipped
        run_read(32'h0000_0000, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule